// File: doc/BRIEF.md
# Byte-Masked Dual-Clock Word Memory

This block is a word-organised storage array with two fully independent access ports, A and B. Each port has its own clock and its own reset. Each port can read a 32-bit word or write any mix of its four 8-bit lanes. Every control, address and data input is sampled on the rising edge of the port's own clock.

A port does something only when its sampled select is low. If the sampled write strobe is also low, the port writes the lanes whose lane strobes are low, and its output register takes the complete sampled write word. If the sampled write strobe is high, the port reads: the stored word at the sampled address lands in the output register. While a port is deselected, its output register keeps its last value.

The storage is split into two banks, one written only by each port. A word is stored as the exclusive-or of the two banks. Each bank therefore has one writer in one clock domain, and both ports see the same contents. The result of both ports writing the same word in overlapping cycles is undefined.

Top module: `bmdp_ram`

## Requirements
- R1: While a port's reset input is low, that port's output reads zero and none of its write requests change memory. After release, the output stays zero until the port's first selected access.
- R2: A selected cycle with the write strobe high puts the stored word at the sampled address on the port output after that rising edge.
- R3: A selected cycle with the write strobe low puts the entire sampled write word on the port output after that rising edge, whatever the lane strobes are.
- R4: On a write, lane strobe i (active low) controls bits 8*i+7 to 8*i: lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24. Lanes whose strobe is high keep their stored bytes.
- R5: A cycle with the select high leaves the memory unchanged and keeps the port output at its previous value, whatever the other inputs are.
- R6: A write with all four lane strobes high leaves the stored word unchanged, but the output still shows the write word.
- R7: A word written through one port is returned by a later read through the other port.
- R8: The two ports may access different addresses in the same period, and each completes correctly.
- R9: The depth is 2 to the power of ADDR_W. Address 0 and address 2^ADDR_W-1 are separate words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A reset, active low, asynchronous assert |
| cs_a_n | input | 1 | Port A select, active low |
| we_a_n | input | 1 | Port A write strobe, active low |
| be_a_n | input | 4 | Port A lane strobes, active low, bit i for byte i |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | 32 | Port A write word |
| rdata_a | output | 32 | Port A registered output |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B reset, active low, asynchronous assert |
| cs_b_n | input | 1 | Port B select, active low |
| we_b_n | input | 1 | Port B write strobe, active low |
| be_b_n | input | 4 | Port B lane strobes, active low, bit i for byte i |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | 32 | Port B write word |
| rdata_b | output | 32 | Port B registered output |

## Verification
The properties assume that each port's inputs are steady around its own rising edge. They also assume that the internal synchronised reset, rather than the raw reset pin, marks when a port is live, since the first edges after release are still blocked. Stimulus changes every input on a falling edge of the clock that samples it, and waits three cycles after any reset release before the next access. The stimulus never lets both ports write the same word in overlapping cycles. Reads of a word through one port happen only after the other port's write to that word has completed.

// File: rtl/bmdp_pkg.sv
package bmdp_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = LANE_W * LANES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;
endpackage

// File: rtl/bmdp_rst_sync.sv
module bmdp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/bmdp_bank.sv
module bmdp_bank
  import bmdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  lane_t             wr_lane_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_word,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output word_t             rd_word_a,
  output word_t             rd_word_b
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lane_en[g]) begin
        cells[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
      end
    end

    assign rd_word_a[g*LANE_W +: LANE_W] = cells[rd_addr_a];
    assign rd_word_b[g*LANE_W +: LANE_W] = cells[rd_addr_b];
  end
endmodule

// File: rtl/bmdp_port.sv
module bmdp_port
  import bmdp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n,
  input  logic  we_n,
  input  lane_t be_n,
  input  word_t wdata,
  input  word_t own_word,
  input  word_t peer_word,
  output lane_t lane_wr_en,
  output word_t wr_word,
  output word_t rdata
);
  logic  access;
  logic  is_write;
  word_t rdata_q;
  word_t rdata_nxt;
  logic  rdata_en;

  always_comb begin
    access     = !cs_n && rst_n;
    is_write   = access && !we_n;
    lane_wr_en = is_write ? ~be_n : '0;
    wr_word    = wdata ^ peer_word;
    rdata_en   = access;
    rdata_nxt  = we_n ? (own_word ^ peer_word) : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_nxt;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/bmdp_ram.sv
module bmdp_ram
  import bmdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              cs_a_n,
  input  logic              we_a_n,
  input  logic [3:0]        be_a_n,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [31:0]       wdata_a,
  output logic [31:0]       rdata_a,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              cs_b_n,
  input  logic              we_b_n,
  input  logic [3:0]        be_b_n,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [31:0]       wdata_b,
  output logic [31:0]       rdata_b
);
  logic  rst_a_sync_n;
  logic  rst_b_sync_n;
  lane_t lane_en_a;
  lane_t lane_en_b;
  word_t wr_word_a;
  word_t wr_word_b;
  word_t bank_a_at_a;
  word_t bank_a_at_b;
  word_t bank_b_at_a;
  word_t bank_b_at_b;

  bmdp_rst_sync #(.STAGES(2)) u_rst_a (
    .clk(clk_a), .arst_n(rst_a_n), .rst_n_o(rst_a_sync_n)
  );

  bmdp_rst_sync #(.STAGES(2)) u_rst_b (
    .clk(clk_b), .arst_n(rst_b_n), .rst_n_o(rst_b_sync_n)
  );

  bmdp_port u_port_a (
    .clk(clk_a), .rst_n(rst_a_sync_n), .cs_n(cs_a_n), .we_n(we_a_n),
    .be_n(be_a_n), .wdata(wdata_a), .own_word(bank_a_at_a),
    .peer_word(bank_b_at_a), .lane_wr_en(lane_en_a), .wr_word(wr_word_a),
    .rdata(rdata_a)
  );

  bmdp_port u_port_b (
    .clk(clk_b), .rst_n(rst_b_sync_n), .cs_n(cs_b_n), .we_n(we_b_n),
    .be_n(be_b_n), .wdata(wdata_b), .own_word(bank_b_at_b),
    .peer_word(bank_a_at_b), .lane_wr_en(lane_en_b), .wr_word(wr_word_b),
    .rdata(rdata_b)
  );

  bmdp_bank #(.ADDR_W(ADDR_W)) u_bank_a (
    .clk(clk_a), .wr_lane_en(lane_en_a), .wr_addr(addr_a), .wr_word(wr_word_a),
    .rd_addr_a(addr_a), .rd_addr_b(addr_b),
    .rd_word_a(bank_a_at_a), .rd_word_b(bank_a_at_b)
  );

  bmdp_bank #(.ADDR_W(ADDR_W)) u_bank_b (
    .clk(clk_b), .wr_lane_en(lane_en_b), .wr_addr(addr_b), .wr_word(wr_word_b),
    .rd_addr_a(addr_a), .rd_addr_b(addr_b),
    .rd_word_a(bank_b_at_a), .rd_word_b(bank_b_at_b)
  );
endmodule

// File: rtl/bmdp_ram_chk.sv
module bmdp_ram_chk (
  input logic        clk_a,
  input logic        rst_a_q_n,
  input logic        cs_a_n,
  input logic        we_a_n,
  input logic [31:0] wdata_a,
  input logic [31:0] rdata_a,
  input logic        clk_b,
  input logic        rst_b_q_n,
  input logic        cs_b_n,
  input logic        we_b_n,
  input logic [31:0] wdata_b,
  input logic [31:0] rdata_b
);
  // R3: a write cycle shows the full write word on the output
  a_r3_through_a: assert property (@(posedge clk_a) disable iff (!rst_a_q_n)
    (!cs_a_n && !we_a_n) |=> (rdata_a == $past(wdata_a)));
  a_r3_through_b: assert property (@(posedge clk_b) disable iff (!rst_b_q_n)
    (!cs_b_n && !we_b_n) |=> (rdata_b == $past(wdata_b)));

  // R5: a deselected cycle keeps the output
  a_r5_hold_a: assert property (@(posedge clk_a) disable iff (!rst_a_q_n)
    cs_a_n |=> $stable(rdata_a));
  a_r5_hold_b: assert property (@(posedge clk_b) disable iff (!rst_b_q_n)
    cs_b_n |=> $stable(rdata_b));
endmodule

bind bmdp_ram bmdp_ram_chk u_chk (
  .clk_a(clk_a), .rst_a_q_n(rst_a_sync_n), .cs_a_n(cs_a_n), .we_a_n(we_a_n),
  .wdata_a(wdata_a), .rdata_a(rdata_a),
  .clk_b(clk_b), .rst_b_q_n(rst_b_sync_n), .cs_b_n(cs_b_n), .we_b_n(we_b_n),
  .wdata_b(wdata_b), .rdata_b(rdata_b)
);

// File: tb/bmdp_ram_tb_top.sv
module bmdp_ram_tb_top;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk_a, rst_a_n, cs_a_n, we_a_n;
  logic [3:0] be_a_n;
  logic [AW-1:0] addr_a;
  logic [31:0] wdata_a, rdata_a;
  logic clk_b, rst_b_n, cs_b_n, we_b_n;
  logic [3:0] be_b_n;
  logic [AW-1:0] addr_b;
  logic [31:0] wdata_b, rdata_b;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model [DEPTH];

  bmdp_ram #(.ADDR_W(AW)) dut_i (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .cs_a_n(cs_a_n), .we_a_n(we_a_n),
    .be_a_n(be_a_n), .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .cs_b_n(cs_b_n), .we_b_n(we_b_n),
    .be_b_n(be_b_n), .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b)
  );

  initial begin clk_a = 0; forever #10 clk_a = ~clk_a; end
  initial begin clk_b = 0; #7; forever #10 clk_b = ~clk_b; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be_n);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (!be_n[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic op_a(input logic we, input logic [3:0] be, input logic [AW-1:0] a,
                      input logic [31:0] d, output logic [31:0] q);
    @(negedge clk_a);
    cs_a_n = 0; we_a_n = we; be_a_n = be; addr_a = a; wdata_a = d;
    @(posedge clk_a);
    @(negedge clk_a);
    q = rdata_a;
    cs_a_n = 1; we_a_n = 1;
  endtask

  task automatic op_b(input logic we, input logic [3:0] be, input logic [AW-1:0] a,
                      input logic [31:0] d, output logic [31:0] q);
    @(negedge clk_b);
    cs_b_n = 0; we_b_n = we; be_b_n = be; addr_b = a; wdata_b = d;
    @(posedge clk_b);
    @(negedge clk_b);
    q = rdata_b;
    cs_b_n = 1; we_b_n = 1;
  endtask

  task automatic write_a(input logic [3:0] be, input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] q;
    op_a(1'b0, be, a, d, q);
    check("R3 port A write-through", q, d);
    model[a] = merge(model[a], d, be);
  endtask

  task automatic write_b(input logic [3:0] be, input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] q;
    op_b(1'b0, be, a, d, q);
    check("R3 port B write-through", q, d);
    model[a] = merge(model[a], d, be);
  endtask

  task automatic read_a(input logic [AW-1:0] a, input string req);
    logic [31:0] q;
    op_a(1'b1, 4'hF, a, 32'h0, q);
    check(req, q, model[a]);
  endtask

  task automatic read_b(input logic [AW-1:0] a, input string req);
    logic [31:0] q;
    op_b(1'b1, 4'hF, a, 32'h0, q);
    check(req, q, model[a]);
  endtask

  task automatic t_reset_state;
    check("R1 port A zero after reset", rdata_a, 32'h0);
    check("R1 port B zero after reset", rdata_b, 32'h0);
  endtask

  task automatic t_basic_rw;
    write_a(4'h0, 6'd3, 32'h1234_5678);
    read_a(6'd3, "R2 port A read");
    write_b(4'h0, 6'd9, 32'h89AB_CDEF);
    read_b(6'd9, "R2 port B read");
  endtask

  task automatic t_lanes;
    write_a(4'h0, 6'd12, 32'hAAAA_AAAA);
    for (int i = 0; i < 4; i++) begin
      write_a(~(4'b1 << i), 6'd12, 32'h1122_3344 + i);
      read_a(6'd12, "R4 single lane write");
    end
    write_b(4'b1010, 6'd12, 32'h5566_7788);
    read_b(6'd12, "R4 lanes 0 and 2 through port B");
  endtask

  task automatic t_no_lanes;
    write_a(4'h0, 6'd20, 32'h0F0F_0F0F);
    write_a(4'hF, 6'd20, 32'hDEAD_BEEF);
    read_a(6'd20, "R6 all lane strobes high keeps word");
  endtask

  task automatic t_deselect;
    logic [31:0] held;
    read_a(6'd3, "R2 read before idle");
    held = rdata_a;
    @(negedge clk_a);
    cs_a_n = 1; we_a_n = 0; be_a_n = 4'h0; addr_a = 6'd3; wdata_a = 32'hFFFF_0000;
    repeat (3) @(negedge clk_a);
    check("R5 output held while deselected", rdata_a, held);
    we_a_n = 1;
    read_a(6'd3, "R5 memory unchanged by deselected cycles");
  endtask

  task automatic t_cross;
    write_a(4'h0, 6'd30, 32'hC0DE_0001);
    read_b(6'd30, "R7 A write seen by B");
    write_b(4'b1100, 6'd30, 32'h0000_BEEF);
    read_a(6'd30, "R7 B lane write seen by A");
  endtask

  task automatic t_parallel;
    fork
      write_a(4'h0, 6'd40, 32'h4040_4040);
      write_b(4'h0, 6'd41, 32'h4141_4141);
    join
    fork
      read_a(6'd41, "R8 parallel read A");
      read_b(6'd40, "R8 parallel read B");
    join
  endtask

  task automatic t_bounds;
    write_a(4'h0, 6'd0, 32'h0000_0BAD);
    write_b(4'h0, DEPTH - 1, 32'hFFFF_0ACE);
    read_b(6'd0, "R9 lowest address");
    read_a(DEPTH - 1, "R9 highest address");
  endtask

  task automatic t_reset_blocks;
    write_a(4'h0, 6'd5, 32'h5A5A_5A5A);
    @(negedge clk_a);
    rst_a_n = 0;
    cs_a_n = 0; we_a_n = 0; be_a_n = 4'h0; addr_a = 6'd5; wdata_a = 32'h1111_1111;
    repeat (2) @(negedge clk_a);
    check("R1 output zero during reset", rdata_a, 32'h0);
    rst_a_n = 1; cs_a_n = 1; we_a_n = 1;
    repeat (3) @(negedge clk_a);
    check("R1 output zero after release before access", rdata_a, 32'h0);
    read_a(6'd5, "R1 writes blocked during reset");
  endtask

  initial begin
    rst_a_n = 1; rst_b_n = 1;
    cs_a_n = 1; we_a_n = 1; be_a_n = 4'hF; addr_a = '0; wdata_a = '0;
    cs_b_n = 1; we_b_n = 1; be_b_n = 4'hF; addr_b = '0; wdata_b = '0;
    #1;
    rst_a_n = 0; rst_b_n = 0;
    repeat (5) @(negedge clk_a);
    rst_a_n = 1; rst_b_n = 1;
    repeat (4) @(negedge clk_a);
    t_reset_state();
    t_basic_rw();
    t_lanes();
    t_no_lanes();
    t_deselect();
    t_cross();
    t_parallel();
    t_bounds();
    t_reset_blocks();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule